// File: doc/BRIEF.md
# Character Display Bus Register File

This block is the host-side slave of an eight-digit character display. A host drives an 8-bit data bus, a five-bit address and active-low chip enable, write, read, flash-select and reset strobes. The block turns each access into a read or a write of one of five storage areas. These are a per-digit character store, a per-digit flash bit store, a pointer that selects one of sixteen user-drawn glyphs, the glyph dot store itself, and an attribute control byte. The refresh logic elsewhere in the chip reads the stored contents through dedicated outputs.

All strobes, address and data pass through a two-stage synchroniser before the block uses them. A write takes effect once, at the rising edge of the synchronised write strobe. The block reports a busy window after reset is released and after a clear command. During that window writes are dropped. The clear command is a self-resetting bit in the control byte. It blanks the character store and the flash store and then returns to zero by itself.

Top module: `disp_bus_regs`

## Requirements
- R1: While `rst_n` is low, and after it goes high, every character location reads 0x20, all flash bits are 0 and the control byte is 0x00. `busy` stays high for CLR_CYCLES (3) clocks after the first clock edge with `rst_n` high.
- R2: Reset does not change the glyph pointer or the glyph dot store.
- R3: With `fl_n` low, the access goes to the flash store whatever addr[4:3] holds. addr[2:0] is the digit and only data bit 0 is stored. A read returns {7'b0, bit}.
- R4: With `fl_n` high and addr[4:3]=11, the access goes to the character store. All 8 bits are stored at digit addr[2:0], with addr[2] as the most significant bit. Digit i appears on `char_flat[8i+7:8i]`, and digit 0 is the leftmost.
- R5: With `fl_n` high and addr[4:3]=00, data[3:0] is stored in the glyph pointer. A read returns {4'b0, pointer}.
- R6: With `fl_n` high and addr[4:3]=01, data[4:0] is stored in row addr[2:0] of the glyph that the pointer selects. Row codes 0 to 6 stand for rows 1 to 7, and data[4] is the leftmost dot. Row code 7 is ignored and reads 0. Upper read bits are 0.
- R7: With `fl_n` high and addr[4:3]=10, the control byte is written. Bit 5 cannot be written: a read returns `selftest_ok` in bit 5 and the stored bits elsewhere.
- R8: A control write with bit 7 set blanks every character location to 0x20 and every flash bit to 0, and raises `busy` for CLR_CYCLES clocks. Bit 7 then returns to 0. The other control bits and the glyph storage are kept.
- R9: A write whose strobe edge is seen while `busy` is high has no effect.
- R10: A write takes effect only when `ce_n` is low at the rising edge of `wr_n`. A write strobe with `ce_n` high changes nothing.
- R11: `data_oe` is high only while both `rd_n` and `ce_n` are low, and `data_out` then carries the addressed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low display reset |
| ce_n | input | 1 | Chip enable, active low |
| wr_n | input | 1 | Write strobe, data taken on its rising edge |
| rd_n | input | 1 | Read strobe, active low |
| fl_n | input | 1 | Flash store select, active low |
| addr | input | 5 | Area select [4:3] and location [2:0] |
| data_in | input | 8 | Bus data from host |
| data_out | output | 8 | Bus data to host |
| data_oe | output | 1 | Bus drive enable toward host |
| selftest_ok | input | 1 | Self-test result returned in control bit 5 |
| busy | output | 1 | Reset or clear window in progress |
| char_flat | output | 64 | Character store, digit i at [8i+7:8i] |
| flash_bits | output | 8 | Flash store, bit i for digit i |
| ctrl_word | output | 8 | Stored control byte |
| glyph_sel | input | 4 | Refresh-side glyph index |
| glyph_row | input | 3 | Refresh-side row code 0..6 |
| glyph_dots | output | 5 | Dots of the selected glyph row |

## Verification
Two functions can land in the same cycle: the blanking done by a clear command, and a host write that reaches the character store before the clear window has ended. The bench issues the clear write and, one cycle after its strobe rises, a second short write strobe to a character location. The rising edge of that second strobe is detected inside the busy window. The location must still read 0x20 after the window. The self-clearing bit must be back at 0, and the brightness and flash bits of the control byte must be unchanged.

// File: rtl/disp_pkg.sv
// Shared widths, constants and the area code for the display bus register file.
// Assumes an 8-digit display with 16 user glyphs of 7 rows by 5 dots.
package disp_pkg;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 5;
    localparam int DIGITS    = 8;
    localparam int DIG_W     = $clog2(DIGITS);
    localparam int GLYPHS    = 16;
    localparam int GLYPH_W   = $clog2(GLYPHS);
    localparam int ROWS      = 7;
    localparam int ROW_W     = $clog2(ROWS + 1);
    localparam int DOTS      = 5;
    localparam logic [DATA_W-1:0] BLANK_CHAR = 8'h20;

    // Storage area selected by one access
    typedef enum logic [2:0] {
        AREA_FLASH,
        AREA_GPTR,
        AREA_GRAM,
        AREA_CTRL,
        AREA_CHAR
    } area_e;

    // One sample of the host bus
    typedef struct packed {
        logic              ce_n;
        logic              wr_n;
        logic              rd_n;
        logic              fl_n;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_smp_t;
endpackage

// File: rtl/disp_bus_sync.sv
// Synchroniser for the host bus. It delays the bus sample through three stages and
// flags a write strobe rising edge, using strobes and fields from the stage before that edge.
// Assumes the host keeps address and data steady around the write strobe.
module disp_bus_sync
    import disp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  bus_smp_t bus_in,
    output bus_smp_t bus_now,
    output bus_smp_t bus_wr,
    output logic     wr_edge
);
    localparam bus_smp_t IDLE = '{ce_n: 1'b1, wr_n: 1'b1, rd_n: 1'b1, fl_n: 1'b1,
                                  addr: '0, data: '0};

    bus_smp_t s1, s2, s3;

    // Three-stage sample pipeline (two for metastability, one for edge detection)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= IDLE;
            s2 <= IDLE;
            s3 <= IDLE;
        end else begin
            s1 <= bus_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign bus_now = s2;
    assign bus_wr  = s3;
    assign wr_edge = !s3.wr_n && s2.wr_n && !s3.ce_n;
endmodule

// File: rtl/disp_area_dec.sv
// Area decoder: the flash select overrides the address, otherwise addr[4:3] selects.
// Purely combinational.
module disp_area_dec
    import disp_pkg::*;
(
    input  logic              fl_n,
    input  logic [ADDR_W-1:0] addr,
    output area_e             area
);
    // Map flash select and upper address bits to a storage area
    always_comb begin
        if (!fl_n) begin
            area = AREA_FLASH;
        end else begin
            case (addr[4:3])
                2'b00:   area = AREA_GPTR;
                2'b01:   area = AREA_GRAM;
                2'b10:   area = AREA_CTRL;
                default: area = AREA_CHAR;
            endcase
        end
    end
endmodule

// File: rtl/disp_store.sv
// Storage for the five areas, the busy window counter and the read mux.
// Assumes wr_en is a single-cycle pulse. Glyph storage has no reset by design.
module disp_store
    import disp_pkg::*;
#(
    parameter int CLR_CYCLES = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  area_e                      wr_area,
    input  logic [DIG_W-1:0]           wr_sel,
    input  logic [DATA_W-1:0]          wr_data,
    input  area_e                      rd_area,
    input  logic [DIG_W-1:0]           rd_sel,
    input  logic                       selftest_ok,
    input  logic [GLYPH_W-1:0]         glyph_sel,
    input  logic [ROW_W-1:0]           glyph_row,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       busy,
    output logic [DIGITS*DATA_W-1:0]   char_flat,
    output logic [DIGITS-1:0]          flash_bits,
    output logic [DATA_W-1:0]          ctrl_word,
    output logic [DOTS-1:0]            glyph_dots
);
    localparam int CNT_W = $clog2(CLR_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CLR_CYCLES);

    logic [DATA_W-1:0]  char_mem [DIGITS];
    logic [DOTS-1:0]    glyph_mem [GLYPHS][ROWS];
    logic [GLYPH_W-1:0] gptr;
    logic [CNT_W-1:0]   cnt;
    logic               accept;

    assign busy   = (cnt != '0);
    assign accept = wr_en && !busy && rst_n;

    // Character store, flash store, control byte and busy window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DIGITS; i++) char_mem[i] <= BLANK_CHAR;
            flash_bits <= '0;
            ctrl_word  <= '0;
            cnt        <= CNT_LOAD;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) ctrl_word[7] <= 1'b0;
        end else if (accept) begin
            case (wr_area)
                AREA_FLASH: flash_bits[wr_sel] <= wr_data[0];
                AREA_CHAR:  char_mem[wr_sel]   <= wr_data;
                AREA_CTRL: begin
                    ctrl_word <= {wr_data[7:6], 1'b0, wr_data[4:0]};
                    if (wr_data[7]) begin
                        for (int i = 0; i < DIGITS; i++) char_mem[i] <= BLANK_CHAR;
                        flash_bits <= '0;
                        cnt        <= CNT_LOAD;
                    end
                end
                default: ;
            endcase
        end
    end

    // Glyph pointer and glyph dot store, kept across reset
    always_ff @(posedge clk) begin
        if (accept && wr_area == AREA_GPTR) gptr <= wr_data[GLYPH_W-1:0];
        if (accept && wr_area == AREA_GRAM && int'(wr_sel) < ROWS)
            glyph_mem[gptr][wr_sel] <= wr_data[DOTS-1:0];
    end

    // Flatten the character store for the refresh side
    generate
        for (genvar d = 0; d < DIGITS; d++) begin : g_flat
            assign char_flat[d*DATA_W +: DATA_W] = char_mem[d];
        end
    endgenerate

    // Refresh-side glyph row lookup
    always_comb begin
        glyph_dots = '0;
        if (int'(glyph_row) < ROWS) glyph_dots = glyph_mem[glyph_sel][glyph_row];
    end

    // Host read mux, unused bits forced to zero
    always_comb begin
        rd_data = '0;
        case (rd_area)
            AREA_FLASH: rd_data[0] = flash_bits[rd_sel];
            AREA_GPTR:  rd_data[GLYPH_W-1:0] = gptr;
            AREA_GRAM:  if (int'(rd_sel) < ROWS) rd_data[DOTS-1:0] = glyph_mem[gptr][rd_sel];
            AREA_CTRL:  rd_data = {ctrl_word[7:6], selftest_ok, ctrl_word[4:0]};
            default:    rd_data = char_mem[rd_sel];
        endcase
    end
endmodule

// File: rtl/disp_bus_regs.sv
// Top of the display bus register file: synchroniser, two area decoders
// (one for the write stage, one for the read stage), storage and registered read port.
// Assumes the host respects the busy window; late writes are dropped.
module disp_bus_regs
    import disp_pkg::*;
#(
    parameter int CLR_CYCLES = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ce_n,
    input  logic                     wr_n,
    input  logic                     rd_n,
    input  logic                     fl_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        data_in,
    output logic [DATA_W-1:0]        data_out,
    output logic                     data_oe,
    input  logic                     selftest_ok,
    output logic                     busy,
    output logic [DIGITS*DATA_W-1:0] char_flat,
    output logic [DIGITS-1:0]        flash_bits,
    output logic [DATA_W-1:0]        ctrl_word,
    input  logic [GLYPH_W-1:0]       glyph_sel,
    input  logic [ROW_W-1:0]         glyph_row,
    output logic [DOTS-1:0]          glyph_dots
);
    bus_smp_t          bus_in, bus_now, bus_wr;
    logic              wr_edge;
    area_e             wr_area, rd_area;
    logic [DATA_W-1:0] rd_data;

    assign bus_in = '{ce_n: ce_n, wr_n: wr_n, rd_n: rd_n, fl_n: fl_n, addr: addr, data: data_in};

    disp_bus_sync u_sync (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in),
        .bus_now(bus_now), .bus_wr(bus_wr), .wr_edge(wr_edge)
    );

    disp_area_dec u_wdec (.fl_n(bus_wr.fl_n),  .addr(bus_wr.addr),  .area(wr_area));
    disp_area_dec u_rdec (.fl_n(bus_now.fl_n), .addr(bus_now.addr), .area(rd_area));

    disp_store #(.CLR_CYCLES(CLR_CYCLES)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_edge), .wr_area(wr_area), .wr_sel(bus_wr.addr[DIG_W-1:0]),
        .wr_data(bus_wr.data),
        .rd_area(rd_area), .rd_sel(bus_now.addr[DIG_W-1:0]),
        .selftest_ok(selftest_ok), .glyph_sel(glyph_sel), .glyph_row(glyph_row),
        .rd_data(rd_data), .busy(busy), .char_flat(char_flat),
        .flash_bits(flash_bits), .ctrl_word(ctrl_word), .glyph_dots(glyph_dots)
    );

    // Registered read port toward the host
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out <= '0;
            data_oe  <= 1'b0;
        end else begin
            data_oe  <= !bus_now.rd_n && !bus_now.ce_n;
            data_out <= (!bus_now.rd_n && !bus_now.ce_n) ? rd_data : '0;
        end
    end
endmodule

// File: rtl/disp_bus_chk.sv
// Checker for disp_bus_regs: reset contents, busy window and the self-clearing bit.
module disp_bus_chk
    import disp_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     busy,
    input logic [DIGITS*DATA_W-1:0] char_flat,
    input logic [DIGITS-1:0]        flash_bits,
    input logic [DATA_W-1:0]        ctrl_word
);
    logic started = 1'b0;

    // Marks that at least one clock edge has passed
    always_ff @(posedge clk) started <= 1'b1;

    AST_RST_BLANK: assert property (@(posedge clk)
        started && $rose(rst_n) |-> char_flat == {DIGITS{BLANK_CHAR}} && flash_bits == '0 && ctrl_word == '0); // R1
    AST_RST_BUSY: assert property (@(posedge clk)
        started && $rose(rst_n) |-> busy); // R1
    AST_CLR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_word[7] |-> busy); // R8
    AST_CLR_SELF_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !ctrl_word[7]); // R8
    AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(char_flat) && $stable(flash_bits)); // R9
endmodule

bind disp_bus_regs disp_bus_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .char_flat(char_flat),
    .flash_bits(flash_bits), .ctrl_word(ctrl_word)
);

// File: tb/sim_disp_bus_regs.sv
module sim_disp_bus_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, fl_n = 1'b1;
    logic [4:0]  addr = '0;
    logic [7:0]  data_in = '0;
    logic [7:0]  data_out;
    logic        data_oe;
    logic        selftest_ok = 1'b0;
    logic        busy;
    logic [63:0] char_flat;
    logic [7:0]  flash_bits;
    logic [7:0]  ctrl_word;
    logic [3:0]  glyph_sel = '0;
    logic [2:0]  glyph_row = '0;
    logic [4:0]  glyph_dots;
    int          n_chk = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    disp_bus_regs u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .wr_n(wr_n), .rd_n(rd_n), .fl_n(fl_n),
        .addr(addr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .selftest_ok(selftest_ok), .busy(busy), .char_flat(char_flat),
        .flash_bits(flash_bits), .ctrl_word(ctrl_word),
        .glyph_sel(glyph_sel), .glyph_row(glyph_row), .glyph_dots(glyph_dots)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_write(input logic fl, input logic [4:0] a, input logic [7:0] d, input logic ce);
        @(negedge clk);
        ce_n = ce; fl_n = fl; addr = a; data_in = d; wr_n = 1'b0;
        idle(2);
        wr_n = 1'b1;
        idle(2);
        ce_n = 1'b1; fl_n = 1'b1;
        idle(6);
    endtask

    task automatic bus_read(input logic fl, input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        ce_n = 1'b0; fl_n = fl; addr = a; rd_n = 1'b0;
        idle(5);
        d = data_out;
        check("R11 oe during read", 64'(data_oe), 64'd1);
        rd_n = 1'b1; ce_n = 1'b1; fl_n = 1'b1;
        idle(5);
        check("R11 oe after read", 64'(data_oe), 64'd0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        idle(4);
        check("R1 char blank in reset", char_flat, {8{8'h20}});
        check("R1 flash clear", 64'(flash_bits), 64'd0);
        check("R1 ctrl clear", 64'(ctrl_word), 64'd0);
        rst_n = 1'b1;
        idle(2);
        check("R1 busy after release", 64'(busy), 64'd1);
        idle(1);
        check("R1 busy ends", 64'(busy), 64'd0);
    endtask

    task automatic t_char;
        logic [7:0] r;
        bus_write(1'b1, 5'b11_101, 8'h41, 1'b0);
        check("R4 digit5 lane", 64'(char_flat[47:40]), 64'h41);
        bus_write(1'b1, 5'b11_000, 8'h85, 1'b0);
        check("R4 digit0 glyph code", 64'(char_flat[7:0]), 64'h85);
        bus_read(1'b1, 5'b11_101, r);
        check("R4 readback digit5", 64'(r), 64'h41);
    endtask

    task automatic t_flash;
        logic [7:0] r;
        bus_write(1'b0, 5'b11_011, 8'hFF, 1'b0);
        check("R3 flash bit3 only", 64'(flash_bits), 64'h08);
        check("R3 char digit3 untouched", 64'(char_flat[31:24]), 64'h20);
        bus_read(1'b0, 5'b00_011, r);
        check("R3 flash readback", 64'(r), 64'h01);
    endtask

    task automatic t_glyph;
        logic [7:0] r;
        bus_write(1'b1, 5'b00_000, 8'hF9, 1'b0);
        bus_read(1'b1, 5'b00_000, r);
        check("R5 pointer readback", 64'(r), 64'h09);
        for (int row = 0; row < 7; row++)
            bus_write(1'b1, {2'b01, 3'(row)}, 8'hE0 | 8'(row + 1), 1'b0);
        bus_write(1'b1, 5'b01_010, 8'hFF, 1'b0);
        bus_write(1'b1, 5'b01_111, 8'h0A, 1'b0);
        glyph_sel = 4'd9;
        for (int row = 0; row < 7; row++) begin
            glyph_row = 3'(row);
            #1;
            check("R6 glyph rows after row7 write",
                  64'(glyph_dots), (row == 2) ? 64'h1F : 64'(row + 1));
        end
        bus_read(1'b1, 5'b01_010, r);
        check("R6 row readback", 64'(r), 64'h1F);
        bus_read(1'b1, 5'b01_111, r);
        check("R6 row code 7 reads 0", 64'(r), 64'h00);
    endtask

    task automatic t_ctrl;
        logic [7:0] r;
        bus_write(1'b1, 5'b10_000, 8'h3B, 1'b0);
        check("R7 stored bit5 dropped", 64'(ctrl_word), 64'h1B);
        selftest_ok = 1'b0;
        bus_read(1'b1, 5'b10_000, r);
        check("R7 read result 0", 64'(r), 64'h1B);
        selftest_ok = 1'b1;
        bus_read(1'b1, 5'b10_000, r);
        check("R7 read result 1", 64'(r), 64'h3B);
    endtask

    task automatic t_clear_collide;
        logic [7:0] r;
        bus_write(1'b1, 5'b11_010, 8'h55, 1'b0);
        bus_write(1'b0, 5'b00_110, 8'h01, 1'b0);
        @(negedge clk);
        ce_n = 1'b0; fl_n = 1'b1; addr = 5'b10_000; data_in = 8'h93; wr_n = 1'b0;
        idle(2);
        wr_n = 1'b1;
        idle(1);
        addr = 5'b11_100; data_in = 8'h66; wr_n = 1'b0;
        idle(1);
        wr_n = 1'b1;
        idle(1);
        ce_n = 1'b1;
        idle(10);
        check("R9 write in clear window dropped", 64'(char_flat[39:32]), 64'h20);
        check("R8 chars blanked", char_flat, {8{8'h20}});
        check("R8 flash cleared", 64'(flash_bits), 64'd0);
        check("R8 bit7 self reset", 64'(ctrl_word), 64'h13);
        glyph_sel = 4'd9; glyph_row = 3'd2;
        #1;
        check("R8 glyph kept", 64'(glyph_dots), 64'h1F);
    endtask

    task automatic t_reset_keeps_glyph;
        logic [7:0] r;
        t_reset();
        glyph_sel = 4'd9; glyph_row = 3'd2;
        #1;
        check("R2 glyph row survives reset", 64'(glyph_dots), 64'h1F);
        bus_read(1'b1, 5'b00_000, r);
        check("R2 pointer survives reset", 64'(r), 64'h09);
    endtask

    task automatic t_ce_gate;
        bus_write(1'b1, 5'b11_001, 8'h77, 1'b1);
        check("R10 write with ce high ignored", 64'(char_flat[15:8]), 64'h20);
        @(negedge clk);
        rd_n = 1'b0; ce_n = 1'b1;
        idle(5);
        check("R11 no drive with ce high", 64'(data_oe), 64'd0);
        rd_n = 1'b1;
        bus_write(1'b1, 5'b11_001, 8'h77, 1'b0);
        check("R10 write with ce low lands", 64'(char_flat[15:8]), 64'h77);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_char();
        t_flash();
        t_glyph();
        t_ctrl();
        t_clear_collide();
        t_reset_keeps_glyph();
        t_ce_gate();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule